// File: doc/BRIEF.md
# Two-Phase 16-bit Processor Core

This block is a small, self-contained processor that spends exactly two clock cycles on every instruction. In the first (fetch) cycle it reads the word addressed by the program counter into an instruction register and advances the program counter. In the second (execute) cycle it decodes that word, runs the ALU, reads or writes its 256-word unified memory or its sixteen-entry register file, and may redirect the program counter. A single phase flop tracks the active cycle. Both cycles may touch memory and the program counter, so they are kept apart.

Programs and data are written into the internal memory through a preload write port, usually while the core is held in reset. Word address `0xFF` is not storage. A load from it returns the value on `in_data_i`. A store to it drives `out_data_o` together with a one-cycle `out_valid_o` strobe. Register 0 always reads zero. Opcode 0 stops the core until the next reset.

Top module: `twophase_cpu`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0, `phase_o` is 0 (fetch), `halted_o` is 0 and `out_valid_o` is 0, even when the core had halted before.
- R2: Fetch and execute alternate, with `phase_o` at 1 during execute. Each fetch edge loads the instruction and increments `pc_o` by one, so every instruction takes two cycles.
- R3: The instruction word holds the opcode in bits [15:12], d in [11:8], s in [7:4] and t in [3:0]. Opcodes 1 to 6 write R[s] op R[t] into R[d]. The operations are, in order: add and subtract (both modulo 2^16), AND, XOR, shift left and logical shift right. A shift amount of 16 or more gives zero.
- R4: Format-2 instructions take an 8-bit address from bits [7:0]. Opcode 7 writes that address, zero-extended, into R[d]. Opcode 8 loads mem[addr] into R[d]. Opcode 9 stores R[d] into mem[addr].
- R5: Opcode A loads mem[R[t][7:0]] into R[d]. Opcode B stores R[d] into mem[R[t][7:0]].
- R6: Opcode C branches to addr when R[d] is zero. Opcode D branches to addr only when R[d], read as signed, is strictly greater than zero. Otherwise execution falls through.
- R7: Opcode E sets the PC to R[t][7:0]. Opcode F writes the already-incremented PC, zero-extended, into R[d] and then sets the PC to addr.
- R8: Register 0 reads as zero, and writes to it have no effect.
- R9: A load from address 0xFF, direct or indirect, returns `in_data_i`. A store to 0xFF, direct or indirect, drives R[d] on `out_data_o` with `out_valid_o` high for exactly the one cycle after the execute edge.
- R10: Opcode 0 sets `halted_o` at its execute edge. From then until reset, the PC, phase, registers and memory stay frozen, and `pc_o` holds the halt address plus one.
- R11: When `prog_we_i` is high at a rising clock edge, `prog_data_i` is written into memory at `prog_addr_i`. This write takes priority over a core store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_we_i | input | 1 | Preload write enable |
| prog_addr_i | input | 8 | Preload word address |
| prog_data_i | input | 16 | Preload data |
| in_data_i | input | 16 | Value returned by loads from 0xFF |
| out_data_o | output | 16 | Data of the last store to 0xFF |
| out_valid_o | output | 1 | One-cycle strobe for a store to 0xFF |
| pc_o | output | 8 | Program counter |
| phase_o | output | 1 | 0 during fetch, 1 during execute |
| halted_o | output | 1 | Core stopped by opcode 0 |

## Verification
The first rising edge after reset is released is a fetch edge: half a cycle later `pc_o` has moved to 1 and `phase_o` is 1. One edge after that, the first execute has finished. A store to 0xFF appears on `out_valid_o` in the cycle after its execute edge, and `halted_o` rises at the execute edge of the halt. The bench therefore drives and samples only on falling edges, records every strobe cycle as it happens, and compares the recorded sequence and the frozen `pc_o` only after `halted_o` is seen. A strobe that lasted two cycles, came early or came late would show up as an extra, missing or misordered entry.

// File: rtl/twophase_cpu_pkg.sv
package twophase_cpu_pkg;
  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_AND = 4'h3,
    OP_XOR  = 4'h4, OP_SHL = 4'h5, OP_SHR = 4'h6, OP_LDA = 4'h7,
    OP_LD   = 4'h8, OP_ST  = 4'h9, OP_LDI = 4'hA, OP_STI = 4'hB,
    OP_BZ   = 4'hC, OP_BP  = 4'hD, OP_JR  = 4'hE, OP_JAL = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_XOR, ALU_SHL, ALU_SHR
  } alu_op_e;

  localparam int unsigned OP_W  = 4;
  localparam int unsigned FLD_W = 4;
endpackage

// File: rtl/twophase_cpu_alu.sv
module twophase_cpu_alu
  import twophase_cpu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);
  logic [W-1:0] sum, dif, andv, xorv, shl, shr;

  // all results computed in parallel, one selected
  assign sum  = a_i + b_i;
  assign dif  = a_i - b_i;
  assign andv = a_i & b_i;
  assign xorv = a_i ^ b_i;
  assign shl  = a_i << b_i;
  assign shr  = a_i >> b_i;

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = sum;
      ALU_SUB: y_o = dif;
      ALU_AND: y_o = andv;
      ALU_XOR: y_o = xorv;
      ALU_SHL: y_o = shl;
      ALU_SHR: y_o = shr;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/twophase_cpu_regfile.sv
module twophase_cpu_regfile #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 16,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra_s_i,
  input  logic [AW-1:0] ra_t_i,
  input  logic [AW-1:0] ra_d_i,
  output logic [W-1:0]  rd_s_o,
  output logic [W-1:0]  rd_t_o,
  output logic [W-1:0]  rd_d_o
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_flop
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q <= '0;
        else if (we_i && wa_i == AW'(i))      q <= wd_i;
      end
      assign regs[i] = q;
    end
  end

  assign rd_s_o = regs[ra_s_i];
  assign rd_t_o = regs[ra_t_i];
  assign rd_d_o = regs[ra_d_i];
endmodule

// File: rtl/twophase_cpu_mem.sv
module twophase_cpu_mem #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd_o,
  input  logic          prog_we_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [W-1:0]  prog_data_i
);
  logic [W-1:0] mem [DEPTH];

  // preload port wins over a core store
  always_ff @(posedge clk_i) begin
    if (prog_we_i)  mem[prog_addr_i] <= prog_data_i;
    else if (we_i)  mem[addr_i]      <= wd_i;
  end

  assign rd_o = mem[addr_i];
endmodule

// File: rtl/twophase_cpu_cond.sv
module twophase_cpu_cond #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  output logic         zero_o,
  output logic         pos_o
);
  assign zero_o = (x_i == '0);
  assign pos_o  = !x_i[W-1] && !zero_o;
endmodule

// File: rtl/twophase_cpu.sv
module twophase_cpu
  import twophase_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NREGS  = 16,
  localparam int unsigned RAW   = $clog2(NREGS),
  localparam logic [ADDR_W-1:0] IO_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              phase_o,
  output logic              halted_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              phase_q, halted_q, halted_d;
  logic [DATA_W-1:0] ir_q, out_q;
  logic              out_vld_q, out_vld_d;

  op_e               op;
  logic [RAW-1:0]    f_d, f_s, f_t;
  logic [ADDR_W-1:0] f_addr;

  logic              fetch_en, exec_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rd, ld_data;
  logic              mem_we, is_io, is_store, is_indirect;
  logic              rf_we;
  logic [DATA_W-1:0] rf_wd, rd_s, rd_t, rd_d;
  alu_op_e           alu_op;
  logic [DATA_W-1:0] alu_y;
  logic              d_zero, d_pos;

  assign op     = op_e'(ir_q[DATA_W-1 -: OP_W]);
  assign f_d    = ir_q[DATA_W-OP_W-1 -: FLD_W];
  assign f_s    = ir_q[2*FLD_W-1 -: FLD_W];
  assign f_t    = ir_q[FLD_W-1:0];
  assign f_addr = ir_q[ADDR_W-1:0];

  assign fetch_en = !phase_q && !halted_q;
  assign exec_en  = phase_q && !halted_q;

  assign is_indirect = (op == OP_LDI) || (op == OP_STI);
  assign is_store    = (op == OP_ST)  || (op == OP_STI);
  assign mem_addr    = !phase_q    ? pc_q :
                       is_indirect ? rd_t[ADDR_W-1:0] : f_addr;
  assign is_io       = phase_q && (mem_addr == IO_ADDR);
  assign ld_data     = is_io ? in_data_i : mem_rd;
  assign mem_we      = exec_en && is_store && !is_io;
  assign out_vld_d   = exec_en && is_store && is_io;

  twophase_cpu_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
    .clk_i       (clk_i),
    .we_i        (mem_we),
    .addr_i      (mem_addr),
    .wd_i        (rd_d),
    .rd_o        (mem_rd),
    .prog_we_i   (prog_we_i),
    .prog_addr_i (prog_addr_i),
    .prog_data_i (prog_data_i)
  );

  twophase_cpu_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .wa_i   (f_d),
    .wd_i   (rf_wd),
    .ra_s_i (f_s),
    .ra_t_i (f_t),
    .ra_d_i (f_d),
    .rd_s_o (rd_s),
    .rd_t_o (rd_t),
    .rd_d_o (rd_d)
  );

  always_comb begin
    unique case (op)
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      OP_XOR:  alu_op = ALU_XOR;
      OP_SHL:  alu_op = ALU_SHL;
      OP_SHR:  alu_op = ALU_SHR;
      default: alu_op = ALU_ADD;
    endcase
  end

  twophase_cpu_alu #(.W(DATA_W)) u_alu (
    .op_i (alu_op),
    .a_i  (rd_s),
    .b_i  (rd_t),
    .y_o  (alu_y)
  );

  twophase_cpu_cond #(.W(DATA_W)) u_cond (
    .x_i    (rd_d),
    .zero_o (d_zero),
    .pos_o  (d_pos)
  );

  // register write-back select
  always_comb begin
    rf_we = 1'b0;
    rf_wd = alu_y;
    if (exec_en) begin
      unique case (op)
        OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: rf_we = 1'b1;
        OP_LDA: begin rf_we = 1'b1; rf_wd = DATA_W'(f_addr); end
        OP_LD, OP_LDI: begin rf_we = 1'b1; rf_wd = ld_data; end
        OP_JAL: begin rf_we = 1'b1; rf_wd = DATA_W'(pc_q); end
        default: rf_we = 1'b0;
      endcase
    end
  end

  // next pc and halt
  always_comb begin
    pc_d     = pc_q;
    halted_d = halted_q;
    if (fetch_en) begin
      pc_d = pc_q + 1'b1;
    end else if (exec_en) begin
      unique case (op)
        OP_HALT: halted_d = 1'b1;
        OP_BZ:   if (d_zero) pc_d = f_addr;
        OP_BP:   if (d_pos)  pc_d = f_addr;
        OP_JR:   pc_d = rd_t[ADDR_W-1:0];
        OP_JAL:  pc_d = f_addr;
        default: pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      phase_q   <= 1'b0;
      halted_q  <= 1'b0;
      ir_q      <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      pc_q      <= pc_d;
      halted_q  <= halted_d;
      out_vld_q <= out_vld_d;
      if (!halted_q) phase_q <= !phase_q;
      if (fetch_en)  ir_q    <= mem_rd;
      if (out_vld_d) out_q   <= rd_d;
    end
  end

  assign pc_o        = pc_q;
  assign phase_o     = phase_q;
  assign halted_o    = halted_q;
  assign out_data_o  = out_q;
  assign out_valid_o = out_vld_q;
endmodule

// File: rtl/twophase_cpu_chk.sv
module twophase_cpu_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pc_o,
  input logic              phase_o,
  input logic              halted_o,
  input logic              out_valid_o
);
  a_r2_fetch_then_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !phase_o) |=> phase_o);

  a_r2_fetch_incr_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !phase_o) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  a_r10_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  a_r10_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(pc_o) && !phase_o));

  a_r9_out_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r9_out_after_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !phase_o);
endmodule

bind twophase_cpu twophase_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_o        (pc_o),
  .phase_o     (phase_o),
  .halted_o    (halted_o),
  .out_valid_o (out_valid_o)
);

// File: tb/twophase_cpu_test.sv
module twophase_cpu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [7:0]  prog_addr_i = '0;
  logic [15:0] prog_data_i = '0;
  logic [15:0] in_data_i = '0;
  logic [15:0] out_data_o;
  logic        out_valid_o;
  logic [7:0]  pc_o;
  logic        phase_o;
  logic        halted_o;

  int n_chk = 0, n_fail = 0, n_out = 0, cyc = 0;
  logic [15:0] outs [16];

  twophase_cpu uut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  // record each strobe cycle
  always @(negedge clk_i) if (rst_ni && out_valid_o) begin
    if (n_out < 16) outs[n_out] = out_data_o;
    n_out++;
  end

  // {opcode, a, b, expected}: R3 = R1 op R2
  localparam int NV = 9;
  localparam logic [51:0] VEC [NV] = '{
    {4'h1, 16'h0028, 16'h0064, 16'h008C},
    {4'h1, 16'hFFFF, 16'h0002, 16'h0001},
    {4'h2, 16'h0005, 16'h0007, 16'hFFFE},
    {4'h3, 16'hF0F0, 16'h3C3C, 16'h3030},
    {4'h4, 16'hF0F0, 16'h3C3C, 16'hCCCC},
    {4'h5, 16'h0001, 16'h000F, 16'h8000},
    {4'h5, 16'h1234, 16'h0010, 16'h0000},
    {4'h6, 16'h8000, 16'h0004, 16'h0800},
    {4'h6, 16'hABCD, 16'h0000, 16'hABCD}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    prog_we_i = 1'b1; prog_addr_i = a; prog_data_i = d;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic hold_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    n_out = 0;
  endtask

  task automatic run(input string req);
    rst_ni = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (halted_o) break;
    end
    chk(halted_o, req, {31'd0, halted_o}, 32'd1);
  endtask

  task automatic chk_outs(input string req, input int n, input logic [15:0] e0,
                          input logic [15:0] e1, input logic [15:0] e2);
    logic [15:0] e [3];
    e = '{e0, e1, e2};
    chk(n_out == n, req, n_out, n);
    for (int i = 0; i < n && i < 3; i++) chk(outs[i] == e[i], req, outs[i], e[i]);
  endtask

  initial begin
    @(negedge clk_i);
    // R11: every program below is preloaded through the write port
    // R3: vector table
    for (int v = 0; v < NV; v++) begin
      hold_reset();
      put(8'h00, 16'h8180); put(8'h01, 16'h8281);
      put(8'h02, {VEC[v][51:48], 12'h312});
      put(8'h03, 16'h93FF); put(8'h04, 16'h0000);
      put(8'h80, VEC[v][47:32]); put(8'h81, VEC[v][31:16]);
      run("R3");
      chk_outs("R3", 1, VEC[v][15:0], 16'h0, 16'h0);
    end

    // R1: reset after a halted run clears state
    hold_reset();
    chk(pc_o == 8'h00 && !phase_o && !halted_o && !out_valid_o, "R1",
        {pc_o, 5'd0, phase_o, halted_o, out_valid_o}, 32'h0);

    // R2, R7, R3: example add at 0x20 reached by jump via R1
    put(8'h00, 16'h7328); put(8'h01, 16'h7464); put(8'h02, 16'h7120);
    put(8'h03, 16'hE001); put(8'h20, 16'h1234); put(8'h21, 16'h92FF);
    put(8'h22, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(phase_o && pc_o == 8'h01, "R2", {pc_o, 7'd0, phase_o}, {8'h01, 8'h01});
    @(negedge clk_i);
    chk(!phase_o && pc_o == 8'h01, "R2", {pc_o, 7'd0, phase_o}, {8'h01, 8'h00});
    run("R2");
    chk_outs("R3", 1, 16'h008C, 16'h0, 16'h0);
    chk(pc_o == 8'h23, "R10", pc_o, 8'h23);

    // R10: frozen after halt
    for (int i = 0; i < 10; i++) @(negedge clk_i);
    chk(halted_o && pc_o == 8'h23 && n_out == 1, "R10", {pc_o, n_out[7:0]}, {8'h23, 8'h01});

    // R8: register 0
    hold_reset();
    put(8'h00, 16'h7055); put(8'h01, 16'h90FF); put(8'h02, 16'h7107);
    put(8'h03, 16'h1210); put(8'h04, 16'h92FF); put(8'h05, 16'h0000);
    run("R8");
    chk_outs("R8", 2, 16'h0000, 16'h0007, 16'h0);

    // R9: I/O load direct/indirect, store direct/indirect
    hold_reset();
    in_data_i = 16'h5A3C;
    put(8'h00, 16'h81FF); put(8'h01, 16'h91FF); put(8'h02, 16'h72FF);
    put(8'h03, 16'hA302); put(8'h04, 16'h93FF); put(8'h05, 16'hB102);
    put(8'h06, 16'h0000);
    run("R9");
    chk_outs("R9", 3, 16'h5A3C, 16'h5A3C, 16'h5A3C);

    // R4, R5: direct and indirect memory access
    hold_reset();
    put(8'h00, 16'h7190); put(8'h01, 16'h8280); put(8'h02, 16'hB201);
    put(8'h03, 16'hA301); put(8'h04, 16'h93FF); put(8'h05, 16'h9285);
    put(8'h06, 16'h8485); put(8'h07, 16'h94FF); put(8'h08, 16'h0000);
    put(8'h80, 16'hBEEF); put(8'h90, 16'h0000); put(8'h85, 16'h0000);
    run("R5");
    chk_outs("R4", 2, 16'hBEEF, 16'hBEEF, 16'h0);

    // R6: branches (negative and zero not taken for D)
    hold_reset();
    put(8'h00, 16'h8280); put(8'h01, 16'hD205); put(8'h02, 16'h7311);
    put(8'h03, 16'h93FF); put(8'h04, 16'hC106); put(8'h05, 16'h0000);
    put(8'h06, 16'h7422); put(8'h07, 16'h94FF); put(8'h08, 16'h7501);
    put(8'h09, 16'hD50C); put(8'h0A, 16'h0000); put(8'h0B, 16'h0000);
    put(8'h0C, 16'hD10E); put(8'h0D, 16'h7633); put(8'h0E, 16'h96FF);
    put(8'h0F, 16'h0000); put(8'h80, 16'hFFFF);
    run("R6");
    chk_outs("R6", 3, 16'h0011, 16'h0022, 16'h0033);
    chk(pc_o == 8'h10, "R6", pc_o, 8'h10);

    // R7: jump and link, jump register
    hold_reset();
    put(8'h00, 16'hF310); put(8'h10, 16'h93FF); put(8'h11, 16'h7405);
    put(8'h12, 16'hE004); put(8'h05, 16'h0000);
    run("R7");
    chk_outs("R7", 1, 16'h0001, 16'h0, 16'h0);
    chk(pc_o == 8'h06, "R7", pc_o, 8'h06);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc == 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule